// File: doc/BRIEF.md
# Outgoing-Message Recorder Sequencer

This block controls the memory side of an outgoing-message recorder that keeps its samples in a flash array of 2^ADDR_W words. The default array holds 4096 words of 16 bits. The block drives the flash address, read/write and enable lines. It also drives the load and bus-drive strobes of an analog-to-digital converter and the load strobe of a digital-to-analog converter. It does not touch the sample data itself: in record mode the converter drives the shared data bus, and in play mode the flash drives it.

A record request from idle starts with a single whole-array erase. The block raises its erase request for one cycle and leaves one cycle for the flash busy flag to rise. It then waits until busy is low. After that it writes one converter sample per cycle into ascending addresses, using a counter one bit wider than the address. The counter stops when it reaches the array size.

A play request from idle reads every word in ascending order. Each word is loaded into the output converter one cycle after its read. A 2-bit phase output shows what the block is doing.

Top module: `msg_rec_ctrl`

## Requirements
- R1: After synchronous reset, phase is 2'b00 (idle) and erase_req, adc_load, adc_drive, flash_rw, flash_en and dac_load are all 0.
- R2: A record request seen in idle raises erase_req for exactly one cycle, starting the cycle after the request, with phase 2'b01 (erasing) during that cycle.
- R3: No flash write is issued while flash_busy is 1; the block waits for busy to fall, having allowed one cycle after erase_req for it to rise.
- R4: Recording writes addresses 0 to DEPTH-1 in ascending order, one per cycle. Each write cycle has flash_rw=1, flash_en=1, adc_load=1 and adc_drive=1. Exactly DEPTH writes are issued, with phase 2'b10 (recording).
- R5: A play request seen in idle reads addresses 0 to DEPTH-1 in ascending order with flash_rw=0 and flash_en=1. The converter strobes stay 0, and phase is 2'b11 (playing).
- R6: dac_load is 1 in the cycle right after each read, and only then, giving exactly DEPTH loads carrying the words in address order.
- R7: Play requests are ignored while erasing or recording. Record requests are ignored while playing.
- R8: When record and play requests arrive together in idle, recording (with its erase) is started.
- R9: Exactly one erase is issued per recording; erase_req never rises in any phase other than the start of a recording.
- R10: After the last word of a recording or playback, the block returns to idle (phase 2'b00) with all strobes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rec_req | input | 1 | Start erase-then-record |
| play_req | input | 1 | Start playback |
| flash_busy | input | 1 | Flash erase in progress |
| erase_req | output | 1 | Whole-array erase request, one cycle |
| adc_load | output | 1 | Input converter sample strobe |
| adc_drive | output | 1 | Input converter drives data bus |
| flash_addr | output | ADDR_W | Flash word address |
| flash_rw | output | 1 | 1 = write, 0 = read |
| flash_en | output | 1 | Flash access enable |
| dac_load | output | 1 | Output converter load strobe |
| phase | output | 2 | 00 idle, 01 erasing, 10 recording, 11 playing |

## Verification
The bench builds the block with ADDR_W=5, a 32-word array. With that size, full recordings and playbacks finish in tens of cycles, so the last-word termination and the return to idle are reached several times per run. The same small array leaves room to vary the erase latency of the behavioural flash, from one cycle (busy already low when first sampled) to twenty cycles. It also leaves room to inject ignored requests in every non-idle phase.

// File: rtl/msg_rec_pkg.sv
package msg_rec_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ERASE_REQ,
        ST_ERASE_GAP,
        ST_ERASE_WAIT,
        ST_REC,
        ST_PLAY
    } seq_state_e;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'b00,
        PH_ERASE = 2'b01,
        PH_REC   = 2'b10,
        PH_PLAY  = 2'b11
    } phase_e;

    typedef struct packed {
        logic erase_req;
        logic adc_load;
        logic adc_drive;
        logic rw;
        logic en;
    } strobe_t;

    function automatic phase_e phase_of(seq_state_e s);
        case (s)
            ST_ERASE_REQ, ST_ERASE_GAP, ST_ERASE_WAIT: return PH_ERASE;
            ST_REC:  return PH_REC;
            ST_PLAY: return PH_PLAY;
            default: return PH_IDLE;
        endcase
    endfunction

endpackage

// File: rtl/mrc_counter.sv
module mrc_counter #(
    parameter int CNT_W = 13
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt,
    output logic             done
);
    localparam logic [CNT_W-1:0] LIMIT = {1'b1, {(CNT_W-1){1'b0}}};

    always_ff @(posedge clk) begin
        if (rst || clr) cnt <= '0;
        else if (inc)   cnt <= cnt + 1'b1;
    end

    assign done = (cnt == LIMIT);

    // counter never passes the array size
    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (rst)
        cnt[CNT_W-1] |-> (cnt[CNT_W-2:0] == '0));

    p_cnt_hold_at_limit_r10: assert property (@(posedge clk) disable iff (rst)
        (done && !clr) |=> done);
endmodule

// File: rtl/mrc_fsm.sv
module mrc_fsm
    import msg_rec_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       rec_req,
    input  logic       play_req,
    input  logic       busy,
    input  logic       cnt_done,
    output seq_state_e state,
    output logic       cnt_clr,
    output logic       cnt_inc
);
    seq_state_e nxt;

    always_comb begin
        nxt = state;
        case (state)
            ST_IDLE: begin
                if (rec_req)       nxt = ST_ERASE_REQ;
                else if (play_req) nxt = ST_PLAY;
            end
            ST_ERASE_REQ:  nxt = ST_ERASE_GAP;
            ST_ERASE_GAP:  nxt = ST_ERASE_WAIT;
            ST_ERASE_WAIT: if (!busy) nxt = ST_REC;
            ST_REC, ST_PLAY: if (cnt_done) nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

    assign cnt_clr = (state == ST_IDLE);
    assign cnt_inc = ((state == ST_REC) || (state == ST_PLAY)) && !cnt_done;

    // recording only starts after busy was seen low
    p_rec_after_idle_busy_r3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ERASE_WAIT && busy) |=> (state == ST_ERASE_WAIT));

    // a request outside idle changes nothing about the running operation
    p_play_ignored_r7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_REC && !cnt_done) |=> (state == ST_REC));

    p_both_rec_wins_r8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && rec_req && play_req) |=> (state == ST_ERASE_REQ));
endmodule

// File: rtl/mrc_outputs.sv
module mrc_outputs
    import msg_rec_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  seq_state_e        state,
    input  logic [ADDR_W:0]   cnt,
    input  logic              cnt_done,
    output strobe_t           strb,
    output logic [ADDR_W-1:0] addr,
    output logic              dac_load,
    output phase_e            phase
);
    logic rec_act, play_act;

    assign rec_act  = (state == ST_REC)  && !cnt_done;
    assign play_act = (state == ST_PLAY) && !cnt_done;

    always_comb begin
        strb           = '0;
        strb.erase_req = (state == ST_ERASE_REQ);
        strb.adc_load  = rec_act;
        strb.adc_drive = rec_act;
        strb.rw        = rec_act;
        strb.en        = rec_act || play_act;
    end

    assign addr  = cnt[ADDR_W-1:0];
    assign phase = phase_of(state);

    always_ff @(posedge clk) begin
        if (rst) dac_load <= 1'b0;
        else     dac_load <= play_act;
    end

    p_erase_one_cycle_r2: assert property (@(posedge clk) disable iff (rst)
        strb.erase_req |=> !strb.erase_req);

    p_write_strobes_r4: assert property (@(posedge clk) disable iff (rst)
        (strb.en && strb.rw) |-> (strb.adc_load && strb.adc_drive));

    p_addr_step_r4: assert property (@(posedge clk) disable iff (rst)
        (strb.en && $past(strb.en)) |-> (addr == $past(addr) + 1'b1));

    p_read_quiet_adc_r5: assert property (@(posedge clk) disable iff (rst)
        (strb.en && !strb.rw) |-> (!strb.adc_load && !strb.adc_drive));

    p_dac_after_read_r6: assert property (@(posedge clk) disable iff (rst)
        (strb.en && !strb.rw) |=> dac_load);

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE) |-> (!strb.en && !strb.erase_req));
endmodule

// File: rtl/msg_rec_ctrl.sv
module msg_rec_ctrl
    import msg_rec_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rec_req,
    input  logic              play_req,
    input  logic              flash_busy,
    output logic              erase_req,
    output logic              adc_load,
    output logic              adc_drive,
    output logic [ADDR_W-1:0] flash_addr,
    output logic              flash_rw,
    output logic              flash_en,
    output logic              dac_load,
    output logic [1:0]        phase
);
    localparam int CNT_W = ADDR_W + 1;

    seq_state_e       state;
    logic             cnt_clr, cnt_inc, cnt_done;
    logic [CNT_W-1:0] cnt;
    strobe_t          strb;
    phase_e           ph;

    mrc_fsm u_fsm (
        .clk(clk), .rst(rst), .rec_req(rec_req), .play_req(play_req),
        .busy(flash_busy), .cnt_done(cnt_done), .state(state),
        .cnt_clr(cnt_clr), .cnt_inc(cnt_inc)
    );

    mrc_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .clr(cnt_clr), .inc(cnt_inc),
        .cnt(cnt), .done(cnt_done)
    );

    mrc_outputs #(.ADDR_W(ADDR_W)) u_out (
        .clk(clk), .rst(rst), .state(state), .cnt(cnt), .cnt_done(cnt_done),
        .strb(strb), .addr(flash_addr), .dac_load(dac_load), .phase(ph)
    );

    assign erase_req = strb.erase_req;
    assign adc_load  = strb.adc_load;
    assign adc_drive = strb.adc_drive;
    assign flash_rw  = strb.rw;
    assign flash_en  = strb.en;
    assign phase     = ph;

    p_no_write_busy_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(flash_en && flash_rw) |-> !flash_busy);

    p_erase_only_from_idle_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(erase_req) |-> ($past(phase) == 2'b00 && $past(rec_req)));
endmodule

// File: tb/msg_rec_ctrl_bench.sv
`timescale 1ns/1ps
module msg_rec_ctrl_bench;
    localparam int ADDR_W = 5;
    localparam int DEPTH  = 1 << ADDR_W;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rec_req = 1'b0, play_req = 1'b0;
    logic flash_busy;
    logic erase_req, adc_load, adc_drive, flash_rw, flash_en, dac_load;
    logic [ADDR_W-1:0] flash_addr;
    logic [1:0] phase;

    always #2.5 clk = ~clk;

    msg_rec_ctrl #(.ADDR_W(ADDR_W)) u_msg_rec_ctrl (
        .clk(clk), .rst(rst), .rec_req(rec_req), .play_req(play_req),
        .flash_busy(flash_busy), .erase_req(erase_req), .adc_load(adc_load),
        .adc_drive(adc_drive), .flash_addr(flash_addr), .flash_rw(flash_rw),
        .flash_en(flash_en), .dac_load(dac_load), .phase(phase)
    );

    // behavioural flash and converters, evaluated mid-cycle
    logic [15:0] mem [DEPTH];
    logic [15:0] dac_log [DEPTH];
    logic [15:0] rdata = 16'h0;
    logic [15:0] seed = 16'h0;
    int erase_lat = 4;
    int busy_left = 0;
    int erase_cnt = 0, write_cnt = 0, read_cnt = 0, dac_cnt = 0;
    int busy_write = 0, order_err = 0, strobe_err = 0, erase_bad = 0;
    int exp_waddr = 0, exp_raddr = 0;
    int checks = 0, fails = 0;

    assign flash_busy = (busy_left != 0);

    function automatic logic [15:0] sample(input logic [15:0] s, input int a);
        return s ^ (16'(a) * 16'h0123) ^ 16'h5A00;
    endfunction

    always @(negedge clk) begin
        if (!rst) begin
            if (dac_load) begin
                if (dac_cnt < DEPTH) dac_log[dac_cnt] = rdata;
                dac_cnt++;
            end
            if (busy_left > 0) busy_left--;
            if (erase_req) begin
                erase_cnt++;
                if (phase != 2'b01) erase_bad++;
                for (int i = 0; i < DEPTH; i++) mem[i] = 16'hFFFF;
                busy_left = erase_lat;
            end
            if (flash_en && flash_rw) begin
                write_cnt++;
                if (flash_busy) busy_write++;
                if (int'(flash_addr) != exp_waddr) order_err++;
                exp_waddr++;
                if (!adc_load || !adc_drive || phase != 2'b10) strobe_err++;
                mem[flash_addr] = sample(seed, int'(flash_addr));
            end
            if (flash_en && !flash_rw) begin
                read_cnt++;
                if (int'(flash_addr) != exp_raddr) order_err++;
                exp_raddr++;
                if (adc_load || adc_drive || phase != 2'b11) strobe_err++;
                rdata = mem[flash_addr];
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_idle(input bit hold_play);
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (phase == 2'b00) begin
                play_req = 1'b0;
                return;
            end
            if (hold_play) play_req = 1'b1;
        end
        check(0, "R10 timeout", int'(phase), 0);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check(phase == 2'b00, "R1 phase", int'(phase), 0);
        check({erase_req, adc_load, adc_drive, flash_rw, flash_en, dac_load} == 6'b0,
              "R1 strobes", int'({erase_req, adc_load, adc_drive, flash_rw, flash_en, dac_load}), 0);
        rst = 1'b0;
        @(negedge clk);
    endtask

    // record with a given erase latency; optionally poke play throughout
    task automatic t_record(input logic [15:0] s, input int lat, input bit poke_play);
        int e0, w0, d0;
        seed = s; erase_lat = lat; exp_waddr = 0;
        e0 = erase_cnt; w0 = write_cnt; d0 = dac_cnt;
        rec_req = 1'b1;
        @(negedge clk);
        rec_req = 1'b0;
        check(erase_req == 1'b1, "R2 erase high", int'(erase_req), 1);
        check(phase == 2'b01, "R2 phase erasing", int'(phase), 1);
        @(negedge clk);
        check(erase_req == 1'b0, "R2 erase one cycle", int'(erase_req), 0);
        if (poke_play) play_req = 1'b1;
        wait_idle(poke_play);
        check(erase_cnt - e0 == 1, "R9 one erase", erase_cnt - e0, 1);
        check(write_cnt - w0 == DEPTH, "R4 write count", write_cnt - w0, DEPTH);
        check(busy_write == 0, "R3 write while busy", busy_write, 0);
        check(order_err == 0 && strobe_err == 0, "R4 order/strobes", order_err + strobe_err, 0);
        for (int i = 0; i < DEPTH; i++)
            check(mem[i] == sample(s, i), "R4 stored word", int'(mem[i]), int'(sample(s, i)));
        check(dac_cnt == d0, "R7 play ignored", dac_cnt - d0, 0);
        check(phase == 2'b00 && !flash_en, "R10 back to idle", int'(phase), 0);
    endtask

    task automatic t_play(input logic [15:0] s, input bit poke_rec);
        int e0, r0;
        exp_raddr = 0; dac_cnt = 0;
        e0 = erase_cnt; r0 = read_cnt;
        play_req = 1'b1;
        @(negedge clk);
        play_req = 1'b0;
        check(phase == 2'b11, "R5 phase playing", int'(phase), 3);
        check(flash_en && !flash_rw && flash_addr == '0, "R5 first read", int'(flash_addr), 0);
        check(!dac_load, "R6 no load before data", int'(dac_load), 0);
        if (poke_rec) begin
            rec_req = 1'b1;
            repeat (3) @(negedge clk);
            rec_req = 1'b0;
        end
        wait_idle(1'b0);
        @(negedge clk);
        check(read_cnt - r0 == DEPTH, "R5 read count", read_cnt - r0, DEPTH);
        check(dac_cnt == DEPTH, "R6 load count", dac_cnt, DEPTH);
        for (int i = 0; i < DEPTH; i++)
            check(dac_log[i] == sample(s, i), "R6 played word", int'(dac_log[i]), int'(sample(s, i)));
        check(erase_cnt == e0, "R7 record ignored during play", erase_cnt - e0, 0);
        check(order_err == 0 && strobe_err == 0, "R5 order/strobes", order_err + strobe_err, 0);
        check(phase == 2'b00 && !dac_load, "R10 idle after play", int'(phase), 0);
    endtask

    task automatic t_both(input logic [15:0] s);
        int d0;
        seed = s; erase_lat = 3; exp_waddr = 0; d0 = dac_cnt;
        rec_req = 1'b1; play_req = 1'b1;
        @(negedge clk);
        rec_req = 1'b0; play_req = 1'b0;
        check(phase == 2'b01 && erase_req, "R8 record wins", int'(phase), 1);
        wait_idle(1'b0);
        check(dac_cnt == d0, "R8 no playback", dac_cnt - d0, 0);
        check(erase_bad == 0, "R9 erase outside erasing", erase_bad, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_record(16'h1111, 1, 1'b0);
        t_play(16'h1111, 1'b0);
        t_record(16'hBEEF, 20, 1'b1);
        t_play(16'hBEEF, 1'b1);
        t_both(16'h0C0C);
        t_play(16'h0C0C, 1'b0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule